// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Unit

This block keeps the status and interrupt flags of an I2C controller. An existing bit engine reports bus-phase events to it as one-cycle strobes. These events are the rising and the falling edge of the acknowledge (ninth) clock, an own-address match, and a lost arbitration. The engine also supplies the SDA level sampled at the acknowledge clock, the R/W bit of the calling address, and a pulse that marks the start of a new transfer. From these inputs the block sets an interrupt-pending flag, a second-interrupt marker, the slave direction, a direction-valid bit and the received-acknowledge level. It drives a processor interrupt request whenever pending and enabled.

A special case applies when arbitration is lost and the controller is then addressed as a slave. In that case it flags two interrupts: one at the rising edge of the acknowledge clock and one at the falling edge. The marker bit tells software which of the two it is servicing.

Software reaches the block through a one-bit-addressed register port with a combinational read. Address 0 is the control register, with the interrupt enable in bit 0. Address 1 is the status register. The two event flags in the status register are cleared by writing 0 to them.

Top module: `i2c_flag_unit`

## Requirements
- R1: A strobe on `ack_fall` (falling edge of the ninth clock, end of a byte) sets the pending flag (status bit 0) in the next cycle.
- R2: An `addr_match` strobe given together with `ack_rise` marks an address hit. The pending flag for that hit is raised by the `ack_fall` of the same acknowledge clock.
- R3: An `arb_lost` strobe sets the pending flag in the next cycle.
- R4: `irq` is high exactly when the enable (control bit 0, reset 0) and the pending flag are both 1.
- R5: Suppose an `arb_lost` strobe has occurred since the last transfer start, and the next `ack_rise` comes with `addr_match`. Then that `ack_rise` sets pending and leaves the marker (status bit 1) at 0. The following `ack_fall` sets both pending and the marker.
- R6: On `ack_rise` with `addr_match`, the block captures `rw_bit` into status bit 2 (0 = master writes, 1 = master reads) and sets the valid bit (status bit 3). A `xfer_start` strobe clears the valid bit.
- R7: On every `ack_rise`, status bit 4 takes `sda_ack` (0 = acknowledged, 1 = no acknowledge).
- R8: A status write with bit 0 or bit 1 at 0 clears that flag. Writing 1 leaves it unchanged. Bits 2, 3 and 4 ignore writes.
- R9: A set event and a software clear of the same flag in the same cycle leave the flag at 1.
- R10: After reset, the control register reads 0 and the status register reads 0x10: only the received-acknowledge bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_rise | input | 1 | Strobe: rising edge of the acknowledge clock |
| ack_fall | input | 1 | Strobe: falling edge of the acknowledge clock |
| sda_ack | input | 1 | SDA level during the acknowledge clock |
| addr_match | input | 1 | Strobe with `ack_rise`: own address received |
| arb_lost | input | 1 | Strobe: arbitration lost |
| rw_bit | input | 1 | R/W bit of the calling address |
| xfer_start | input | 1 | Strobe: a new transfer has begun |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Processor interrupt request |

## Verification
Two functions can fall in the same cycle: a hardware event setting pending or the marker, and a software write of 0 that clears it. The bench provokes this in two ways. It drives an `ack_fall` together with a status write of zeros, and it drives an `arb_lost` together with such a write. It judges the result by reading the status register in the next cycle and expecting the flag still set. A separate write of ones while pending is 1 confirms that writing 1 neither clears pending nor alters the read-only bits.

// File: rtl/i2c_flag_unit.sv
module i2c_flag_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_rise,
  input  logic          ack_fall,
  input  logic          sda_ack,
  input  logic          addr_match,
  input  logic          arb_lost,
  input  logic          rw_bit,
  input  logic          xfer_start,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);

  localparam int B_PEND = 0;
  localparam int B_AKF  = 1;
  localparam int B_SRW  = 2;
  localparam int B_VLD  = 3;
  localparam int B_RXAK = 4;

  logic ien, pend, akf, srw, srw_vld, rxack;
  logic al_seen, dbl_arm;

  wire sts_wr   = reg_wr && reg_addr;
  wire ctl_wr   = reg_wr && !reg_addr;
  wire dbl_rise = ack_rise && addr_match && al_seen;
  wire set_pend = ack_fall || arb_lost || dbl_rise;
  wire set_akf  = ack_fall && dbl_arm;
  wire clr_pend = sts_wr && !reg_wdata[B_PEND];
  wire clr_akf  = sts_wr && !reg_wdata[B_AKF];

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= 1'b0;
    end else if (ctl_wr) begin
      ien <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      akf  <= 1'b0;
    end else begin
      if (set_pend)      pend <= 1'b1;
      else if (clr_pend) pend <= 1'b0;
      if (set_akf)       akf  <= 1'b1;
      else if (clr_akf)  akf  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al_seen <= 1'b0;
      dbl_arm <= 1'b0;
    end else begin
      if (arb_lost)                 al_seen <= 1'b1;
      else if (xfer_start || ack_rise) al_seen <= 1'b0;
      if (dbl_rise)                 dbl_arm <= 1'b1;
      else if (ack_fall || xfer_start) dbl_arm <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srw     <= 1'b0;
      srw_vld <= 1'b0;
      rxack   <= 1'b1;
    end else begin
      if (ack_rise) rxack <= sda_ack;
      if (ack_rise && addr_match) begin
        srw     <= rw_bit;
        srw_vld <= 1'b1;
      end else if (xfer_start) begin
        srw_vld <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) begin
      reg_rdata[B_PEND] = pend;
      reg_rdata[B_AKF]  = akf;
      reg_rdata[B_SRW]  = srw;
      reg_rdata[B_VLD]  = srw_vld;
      reg_rdata[B_RXAK] = rxack;
    end else begin
      reg_rdata[0] = ien;
    end
  end

  assign irq = ien & pend;

  // R1
  pend_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ack_fall |=> pend);

  // R3
  pend_on_al_chk: assert property (@(posedge clk) disable iff (rst)
    arb_lost |=> pend);

  // R5
  akf_second_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_fall && dbl_arm) |=> (akf && pend));

  // R6
  srw_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_rise && addr_match) |=> (srw_vld && srw == $past(rw_bit)));

  // R7
  rxack_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ack_rise |=> (rxack == $past(sda_ack)));

  // R8
  write_one_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && reg_wdata[B_PEND] && pend) |=> pend);

  // R9
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (set_pend && clr_pend) |=> pend);

endmodule

// File: tb/tb_i2c_flag_unit.sv
`timescale 1ns/1ps
module tb_i2c_flag_unit;
  logic clk = 1'b0;
  logic rst;
  logic ack_rise, ack_fall, sda_ack, addr_match, arb_lost, rw_bit, xfer_start;
  logic reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic irq;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  i2c_flag_unit dut (
    .clk(clk), .rst(rst), .ack_rise(ack_rise), .ack_fall(ack_fall),
    .sda_ack(sda_ack), .addr_match(addr_match), .arb_lost(arb_lost),
    .rw_bit(rw_bit), .xfer_start(xfer_start), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  // input byte: [7]ack_rise [6]ack_fall [5]sda_ack [4]addr_match
  //             [3]arb_lost [2]rw_bit [1]xfer_start [0]status write of 0
  // expected status: [4]rxack [3]valid [2]srw [1]marker [0]pending
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {8'b0000_0010, 5'b10000},  // R6 start
    {8'b1000_0000, 5'b00000},  // R7 ack received
    {8'b0100_0000, 5'b00001},  // R1
    {8'b0000_0001, 5'b00000},  // R8 clear
    {8'b1011_0100, 5'b11100},  // R2 R6 R7 read address hit
    {8'b0100_0000, 5'b11101},  // R2
    {8'b0000_0001, 5'b11100},  // R8
    {8'b0000_0010, 5'b10100},  // R6 valid drops
    {8'b0000_1000, 5'b10101},  // R3
    {8'b0000_0001, 5'b10100},  // R8
    {8'b1001_0000, 5'b01001},  // R5 first
    {8'b0000_0001, 5'b01000},  // R8
    {8'b0100_0000, 5'b01011},  // R5 second
    {8'b0000_0001, 5'b01000},  // R8 clears both
    {8'b0100_0000, 5'b01001},  // R1 no marker
    {8'b0100_0001, 5'b01001}   // R9
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {ack_rise, ack_fall, sda_ack, addr_match, arb_lost, rw_bit, xfer_start} = '0;
    reg_wr = 1'b0; reg_addr = 1'b1; reg_wdata = '0;
  endtask

  task automatic apply(input logic [7:0] v);
    {ack_rise, ack_fall, sda_ack, addr_match, arb_lost, rw_bit, xfer_start} = v[7:1];
    reg_wr = v[0]; reg_addr = 1'b1; reg_wdata = 8'h00;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    idle();
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R10 status", reg_rdata, 8'h10);
    reg_addr = 1'b0; #0.5;
    chk("R10 control", reg_rdata, 8'h00);
    reg_addr = 1'b1;
    chk("R4 irq reset", {7'd0, irq}, 8'h00);

    apply(8'b0000_1000);
    chk("R4 irq disabled", {7'd0, irq}, 8'h00);
    chk("R3 pend", reg_rdata, 8'h11);
    wr_reg(1'b1, 8'hFF);
    chk("R8 write ones", reg_rdata, 8'h11);
    apply(8'b0000_1001);
    chk("R9 al vs clear", reg_rdata, 8'h11);
    apply(8'b0000_0011);
    chk("R8 clear", reg_rdata, 8'h10);
    wr_reg(1'b0, 8'h01);
    reg_addr = 1'b0; #0.5;
    chk("R4 enable", reg_rdata, 8'h01);
    reg_addr = 1'b1; #0.5;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][12:5]);
      chk($sformatf("vector %0d status", i), reg_rdata, {3'd0, VEC[i][4:0]});
      chk($sformatf("R4 vector %0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    wr_reg(1'b0, 8'h00);
    chk("R4 irq off", {7'd0, irq}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule